// File: doc/BRIEF.md
# Flash Command Register Interpreter

This block is the device side of a bulk-erase flash word store that is driven through a two-cycle command protocol. A host presents chip select, write strobe, output enable, a 16-bit address, a 16-bit data bus and a flag that says the high programming voltage is present. All of these are sampled on the system clock. The block finds the falling and rising edges of each write pulse and interprets the data of each completed pulse as a command. Depending on the active mode, read cycles return array contents, identifier codes or verify data.

Changing the array always takes two writes. Programming needs a set-up command followed by the address and data word. Erasing needs the erase code twice in a row. Leaving a set-up without touching the array needs the reset code twice. A program or erase stays active until the next write pulse, which normally carries a verify command. If no such pulse arrives, a stop timer, counted in clock cycles, ends the operation and leaves the block idle until the next command. The array is a small behavioural store. Programming can only clear bits, and erasing sets every word to all ones.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, every word reads FFFFh, `busy` is low, and the interpreter is in array-read mode.
- R2: After command 0090h, a read at bus address 0 returns 0097h and a read at address 1 returns 00E5h. Any other address reads 0000h, so the upper byte is always zero.
- R3: A completed write pulse while `hv_ok` is low changes neither the mode nor the array. Array reads still work in that state.
- R4: After 0040h, the next write programs the word at the address captured on the strobe's falling edge: the new word is the old word AND the data. `busy` is high from the cycle after that pulse's rising edge.
- R5: A following 00C0h write ends the program operation (`busy` falls). Reads then return the most recently programmed word, whatever the bus address.
- R6: Writing 0020h twice in a row sets every word to FFFFh and raises `busy`. A 0020h followed by any other code is decoded as a fresh command and erases nothing.
- R7: Writing 00A0h ends an erase and enters erase-verify mode. Reads then return the word at the address captured on that write's falling edge, until another command is written.
- R8: After a program or erase set-up, two consecutive 00FFh writes return the block to array-read mode with the array unchanged.
- R9: A program lasts at most PGM_STOP_CYC cycles and an erase at most ERS_STOP_CYC cycles. The stop timer then drops `busy`, and reads return array data until a new command arrives.
- R10: An unrecognised command code leaves the current mode unchanged.
- R11: `dout_en` is high only when `ce_n` and `oe_n` are low and `we_n` is high. Otherwise `dout` is 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| we_n | input | 1 | Write strobe, active low |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| hv_ok | input | 1 | High programming voltage present |
| addr | input | 16 | Word address bus |
| din | input | 16 | Write data bus |
| dout | output | 16 | Read data, zero when not enabled |
| dout_en | output | 1 | Read data valid / bus drive enable |
| busy | output | 1 | Program or erase operation in progress |

## Verification
A wrong mode register shows up on the very next read cycle. An identifier code appears where array data was expected, or a verify word is returned for the wrong bus address, or array data is returned where the identifier was due. A broken reset or erase sequence becomes visible as changed array contents on a later plain read. The bench therefore reads back words well after each sequence. A stop timer that is too long or too short shows in `busy` within the configured number of cycles after the operation starts.

// File: rtl/flash_cmd_pkg.sv
// Shared mode type, command codes and the general command decoder.
package flash_cmd_pkg;

    typedef enum logic [3:0] {
        M_READ, M_ID, M_PSETUP, M_PBUSY, M_PVERIFY,
        M_ESETUP, M_EBUSY, M_EVERIFY, M_RSTARM, M_IDLE
    } mode_e;

    localparam logic [15:0] CMD_READ = 16'h0000;
    localparam logic [15:0] CMD_ID   = 16'h0090;
    localparam logic [15:0] CMD_PSET = 16'h0040;
    localparam logic [15:0] CMD_ESET = 16'h0020;
    localparam logic [15:0] CMD_PVFY = 16'h00C0;
    localparam logic [15:0] CMD_EVFY = 16'h00A0;
    localparam logic [15:0] CMD_RST  = 16'h00FF;
    localparam logic [15:0] ID_MAKER = 16'h0097;
    localparam logic [15:0] ID_PART  = 16'h00E5;
    localparam logic [15:0] WORD_ERASED = 16'hFFFF;

    // Maps a command word to the mode it selects; unknown codes keep cur.
    function automatic mode_e decode_cmd(mode_e cur, logic [15:0] d);
        mode_e nx;
        case (d)
            CMD_READ: nx = M_READ;
            CMD_ID:   nx = M_ID;
            CMD_PSET: nx = M_PSETUP;
            CMD_ESET: nx = M_ESETUP;
            CMD_PVFY: nx = M_PVERIFY;
            CMD_EVFY: nx = M_EVERIFY;
            CMD_RST:  nx = M_RSTARM;
            default:  nx = cur;
        endcase
        return nx;
    endfunction

endpackage

// File: rtl/fcr_strobe_det.sv
// Write-strobe edge detector.
// Finds the start and end of each write pulse (we_n and ce_n both low).
// It captures the address at the start of the pulse and keeps the data
// of the last cycle of the pulse.
// Assumes the strobe inputs are already synchronous to clk.
module fcr_strobe_det #(
    parameter int CAP_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_n,
    input  logic             ce_n,
    input  logic [CAP_W-1:0] addr,
    input  logic [15:0]      din,
    output logic             wr_rise,
    output logic [CAP_W-1:0] addr_cap,
    output logic [15:0]      data_cap
);
    logic act, act_q;
    assign act     = !we_n && !ce_n;
    assign wr_rise = act_q && !act;

    // Remember last cycle's strobe state for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= 1'b0;
        else        act_q <= act;
    end

    // Capture the word address on the leading (falling) strobe edge.
    always_ff @(posedge clk) begin
        if (!rst_n)               addr_cap <= '0;
        else if (act && !act_q)   addr_cap <= addr;
    end

    // Track the data bus while the strobe is low; held at the trailing edge.
    always_ff @(posedge clk) begin
        if (!rst_n)    data_cap <= '0;
        else if (act)  data_cap <= din;
    end
endmodule

// File: rtl/fcr_stop_timer.sv
// Stop timer for program and erase.
// It restarts on each operation start and raises expire in the last
// allowed cycle of the operation. Limits are in clock cycles.
module fcr_stop_timer #(
    parameter int PGM_LIM = 2000,
    parameter int ERS_LIM = 20000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    input  logic erase_sel,
    output logic expire
);
    localparam int MAXL = (PGM_LIM > ERS_LIM) ? PGM_LIM : ERS_LIM;
    localparam int CW   = $clog2(MAXL + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    assign lim    = erase_sel ? CW'(ERS_LIM - 1) : CW'(PGM_LIM - 1);
    assign expire = run && (cnt == lim);

    // Count cycles spent in the running operation.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (start)          cnt <= '0;
        else if (run && !expire) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/fcr_word_store.sv
// Behavioural word array.
// Programming ANDs the data into one word; erase sets all words to ones.
// Reset puts the array in the erased state. One asynchronous read port.
module fcr_word_store #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prog_en,
    input  logic [AW-1:0] prog_addr,
    input  logic [15:0]   prog_data,
    input  logic          erase_en,
    input  logic [AW-1:0] rd_addr,
    output logic [15:0]   rd_data
);
    import flash_cmd_pkg::*;
    localparam int DEPTH = 1 << AW;

    logic [15:0] mem [DEPTH];

    // Apply reset, bulk erase or a single-word program.
    always_ff @(posedge clk) begin
        for (int w = 0; w < DEPTH; w++) begin
            if (!rst_n || erase_en)
                mem[w] <= WORD_ERASED;
            else if (prog_en && prog_addr == AW'(w))
                mem[w] <= mem[w] & prog_data;
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/fcr_cmd_fsm.sv
// Command interpreter state machine.
// Acts on each completed write pulse when the programming voltage is
// present. It holds the mode, issues program and erase strobes, and keeps
// the verify addresses. The stop timer moves a running operation to idle.
module fcr_cmd_fsm #(
    parameter int AW = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hv_ok,
    input  logic                 wr_rise,
    input  logic [15:0]          data_cap,
    input  logic [AW-1:0]        addr_cap,
    input  logic                 expire,
    output flash_cmd_pkg::mode_e mode,
    output logic                 prog_en,
    output logic                 erase_en,
    output logic [AW-1:0]        pv_addr,
    output logic [AW-1:0]        ev_addr
);
    import flash_cmd_pkg::*;

    mode_e mode_nx;
    logic  cmd_ok;
    logic  ev_ld;

    assign cmd_ok = wr_rise && hv_ok;

    // Next mode and operation strobes from the current mode and command.
    always_comb begin
        mode_nx  = mode;
        prog_en  = 1'b0;
        erase_en = 1'b0;
        if (cmd_ok) begin
            case (mode)
                M_PSETUP: begin
                    if (data_cap == CMD_RST) mode_nx = M_RSTARM;
                    else begin
                        mode_nx = M_PBUSY;
                        prog_en = 1'b1;
                    end
                end
                M_ESETUP: begin
                    if (data_cap == CMD_ESET) begin
                        mode_nx  = M_EBUSY;
                        erase_en = 1'b1;
                    end else if (data_cap == CMD_RST) mode_nx = M_RSTARM;
                    else mode_nx = decode_cmd(mode, data_cap);
                end
                M_RSTARM: begin
                    if (data_cap == CMD_RST) mode_nx = M_READ;
                    else mode_nx = decode_cmd(mode, data_cap);
                end
                M_PBUSY, M_EBUSY: begin
                    mode_nx = decode_cmd(mode, data_cap);
                    if (mode_nx == mode) mode_nx = M_IDLE;
                end
                default: mode_nx = decode_cmd(mode, data_cap);
            endcase
        end else if (expire) begin
            mode_nx = M_IDLE;
        end
    end

    assign ev_ld = cmd_ok && (data_cap == CMD_EVFY) && (mode_nx == M_EVERIFY);

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) mode <= M_READ;
        else        mode <= mode_nx;
    end

    // Verify addresses: last programmed word and erase-verify target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pv_addr <= '0;
            ev_addr <= '0;
        end else begin
            if (prog_en) pv_addr <= addr_cap;
            if (ev_ld)   ev_addr <= addr_cap;
        end
    end
endmodule

// File: rtl/flash_cmd_ctrl.sv
// Flash command register interpreter, top level.
// Ties the strobe detector, the command state machine, the stop timer and
// the word store together, and selects the read data source by mode.
// Assumes all bus inputs are synchronous to clk.
module flash_cmd_ctrl #(
    parameter int ADDR_W       = 16,
    parameter int STORE_AW     = 6,
    parameter int PGM_STOP_CYC = 2000,
    parameter int ERS_STOP_CYC = 20000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              hv_ok,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       din,
    output logic [15:0]       dout,
    output logic              dout_en,
    output logic              busy
);
    import flash_cmd_pkg::*;

    logic                wr_rise;
    logic [STORE_AW-1:0] addr_cap;
    logic [15:0]         data_cap;
    mode_e               mode;
    logic                prog_en, erase_en, expire;
    logic [STORE_AW-1:0] pv_addr, ev_addr, rd_addr;
    logic [15:0]         rd_data, rd_val;

    fcr_strobe_det #(.CAP_W(STORE_AW)) u_stb (
        .clk(clk), .rst_n(rst_n), .we_n(we_n), .ce_n(ce_n),
        .addr(addr[STORE_AW-1:0]), .din(din),
        .wr_rise(wr_rise), .addr_cap(addr_cap), .data_cap(data_cap)
    );

    fcr_cmd_fsm #(.AW(STORE_AW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .hv_ok(hv_ok), .wr_rise(wr_rise),
        .data_cap(data_cap), .addr_cap(addr_cap), .expire(expire),
        .mode(mode), .prog_en(prog_en), .erase_en(erase_en),
        .pv_addr(pv_addr), .ev_addr(ev_addr)
    );

    fcr_stop_timer #(.PGM_LIM(PGM_STOP_CYC), .ERS_LIM(ERS_STOP_CYC)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(prog_en || erase_en),
        .run(busy), .erase_sel(mode == M_EBUSY), .expire(expire)
    );

    fcr_word_store #(.AW(STORE_AW)) u_mem (
        .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .prog_addr(addr_cap),
        .prog_data(data_cap), .erase_en(erase_en), .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

    assign busy = (mode == M_PBUSY) || (mode == M_EBUSY);

    // Choose which word the read port looks at.
    always_comb begin
        case (mode)
            M_PVERIFY: rd_addr = pv_addr;
            M_EVERIFY: rd_addr = ev_addr;
            default:   rd_addr = addr[STORE_AW-1:0];
        endcase
    end

    // Identifier codes replace array data in identifier mode.
    always_comb begin
        if (mode == M_ID) begin
            if (addr == ADDR_W'(0))      rd_val = ID_MAKER;
            else if (addr == ADDR_W'(1)) rd_val = ID_PART;
            else                         rd_val = '0;
        end else begin
            rd_val = rd_data;
        end
    end

    assign dout_en = !ce_n && !oe_n && we_n;
    assign dout    = dout_en ? rd_val : '0;
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
// Assertion checker for flash_cmd_ctrl, attached with bind below.
module flash_cmd_ctrl_chk #(
    parameter int PGM_STOP_CYC = 2000,
    parameter int ERS_STOP_CYC = 20000
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 hv_ok,
    input logic                 ce_n,
    input logic                 oe_n,
    input logic                 busy,
    input logic                 dout_en,
    input logic [15:0]          dout,
    input flash_cmd_pkg::mode_e mode,
    input logic                 prog_en,
    input logic                 erase_en,
    input logic                 wr_rise
);
    import flash_cmd_pkg::*;
    localparam int MAXL = (PGM_STOP_CYC > ERS_STOP_CYC) ? PGM_STOP_CYC : ERS_STOP_CYC;
    localparam int CW   = $clog2(MAXL + 2);

    logic [CW-1:0] busy_run;

    // Length of the current stretch of busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_run <= '0;
        else if (busy) busy_run <= busy_run + 1'b1;
        else           busy_run <= '0;
    end

    p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !busy);

    p_id_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_ID && dout_en) |-> dout[15:8] == 8'h00);

    p_hv_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!hv_ok && !busy) |=> $stable(mode));

    p_prog_on_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        prog_en |-> (wr_rise && hv_ok));

    p_prog_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        prog_en |=> busy);

    p_erase_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        erase_en |=> busy);

    p_busy_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_run < CW'(MAXL)));

    p_quiet_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || oe_n) |-> (dout == 16'h0000 && !dout_en));
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(
    .PGM_STOP_CYC(PGM_STOP_CYC), .ERS_STOP_CYC(ERS_STOP_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .hv_ok(hv_ok), .ce_n(ce_n), .oe_n(oe_n),
    .busy(busy), .dout_en(dout_en), .dout(dout), .mode(mode),
    .prog_en(prog_en), .erase_en(erase_en), .wr_rise(wr_rise)
);

// File: tb/flash_cmd_ctrl_test.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_test;
    localparam int AW   = 6;
    localparam int PLIM = 30;
    localparam int ELIM = 60;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we_n = 1'b1, ce_n = 1'b1, oe_n = 1'b1, hv_ok = 1'b1;
    logic [15:0] addr = '0, din = '0;
    logic [15:0] dout;
    logic        dout_en, busy;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [15:0] model [1 << AW];

    always #2.5 clk = ~clk;

    flash_cmd_ctrl #(.ADDR_W(16), .STORE_AW(AW), .PGM_STOP_CYC(PLIM),
                     .ERS_STOP_CYC(ELIM)) uut (
        .clk(clk), .rst_n(rst_n), .we_n(we_n), .ce_n(ce_n), .oe_n(oe_n),
        .hv_ok(hv_ok), .addr(addr), .din(din), .dout(dout),
        .dout_en(dout_en), .busy(busy)
    );

    function automatic logic [15:0] exp_id(input logic [15:0] a);
        if (a == 16'h0000) return 16'h0097;
        if (a == 16'h0001) return 16'h00E5;
        return 16'h0000;
    endfunction

    function automatic logic [15:0] exp_prog(input logic [15:0] old, input logic [15:0] d);
        return old & d;
    endfunction

    task automatic chk(input string rq, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk); addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
        repeat (2) @(negedge clk);
        we_n = 1'b1;
        @(negedge clk); ce_n = 1'b1;
    endtask

    task automatic rd(input logic [15:0] a, output logic [15:0] v);
        @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
        #1 v = dout;
        oe_n = 1'b1; ce_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
        finish_run();
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'd1234));
        for (int i = 0; i < (1 << AW); i++) model[i] = 16'hFFFF;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        chk("R1 busy", {15'h0, busy}, 16'h0);
        rd(16'd5, v); chk("R1 erased word", v, 16'hFFFF);
        rd(16'd0, v); chk("R1 array read at addr 0", v, 16'hFFFF);

        // R11: read enable rules
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b1; #1;
        chk("R11 oe high dout", dout, 16'h0);
        chk("R11 oe high en", {15'h0, dout_en}, 16'h0);
        oe_n = 1'b0; #1;
        chk("R11 enabled", {15'h0, dout_en}, 16'h1);
        oe_n = 1'b1; ce_n = 1'b1;

        // R3: no programming voltage, command ignored
        hv_ok = 1'b0;
        wr(16'd0, 16'h0090);
        rd(16'd0, v); chk("R3 id ignored", v, 16'hFFFF);
        hv_ok = 1'b1;

        // R2: identifier mode
        wr(16'd0, 16'h0090);
        rd(16'd0, v); chk("R2 maker", v, exp_id(16'd0));
        rd(16'd1, v); chk("R2 part", v, exp_id(16'd1));
        rd(16'd2, v); chk("R2 other addr", v, exp_id(16'd2));
        // R10: unknown code keeps identifier mode
        wr(16'd0, 16'h0055);
        rd(16'd0, v); chk("R10 mode kept", v, 16'h0097);
        wr(16'd0, 16'h0000);
        rd(16'd0, v); chk("R10 back to read", v, 16'hFFFF);

        // R4/R5: program then verify
        wr(16'd0, 16'h0040);
        wr(16'd3, 16'h1234); model[3] = exp_prog(model[3], 16'h1234);
        chk("R4 busy after program", {15'h0, busy}, 16'h1);
        wr(16'd0, 16'h00C0);
        chk("R5 busy ends", {15'h0, busy}, 16'h0);
        rd(16'd9, v); chk("R5 verify word", v, model[3]);
        wr(16'd0, 16'h0000);
        wr(16'd0, 16'h0040);
        wr(16'd3, 16'hF0F0); model[3] = exp_prog(model[3], 16'hF0F0);
        wr(16'd0, 16'h00C0);
        wr(16'd0, 16'h0000);
        rd(16'd3, v); chk("R4 AND program", v, 16'h1030);

        // R8: double reset after program and erase set-up
        wr(16'd0, 16'h0040); wr(16'd3, 16'h00FF); wr(16'd3, 16'h00FF);
        rd(16'd3, v); chk("R8 program set-up reset", v, model[3]);
        chk("R8 not busy", {15'h0, busy}, 16'h0);
        wr(16'd0, 16'h0020); wr(16'd0, 16'h00FF); wr(16'd0, 16'h00FF);
        rd(16'd3, v); chk("R8 erase set-up reset", v, model[3]);

        // R6: single erase set-up followed by other code erases nothing
        wr(16'd0, 16'h0020); wr(16'd0, 16'h0000);
        rd(16'd3, v); chk("R6 no erase", v, model[3]);

        // R9: program stop timer
        wr(16'd0, 16'h0040); wr(16'd7, 16'h00AA); model[7] = 16'h00AA;
        repeat (10) @(negedge clk);
        chk("R9 program still busy", {15'h0, busy}, 16'h1);
        repeat (PLIM + 5) @(negedge clk);
        chk("R9 program timed out", {15'h0, busy}, 16'h0);
        rd(16'd7, v); chk("R9 idle reads array", v, 16'h00AA);

        // R6/R7: erase and erase verify
        wr(16'd0, 16'h0020); wr(16'd0, 16'h0020);
        for (int i = 0; i < (1 << AW); i++) model[i] = 16'hFFFF;
        chk("R6 erase busy", {15'h0, busy}, 16'h1);
        wr(16'd3, 16'h00A0);
        chk("R7 erase ended", {15'h0, busy}, 16'h0);
        rd(16'd5, v); chk("R6 erased word", v, 16'hFFFF);
        wr(16'd0, 16'h0000);
        rd(16'd7, v); chk("R6 all erased", v, 16'hFFFF);
        wr(16'd0, 16'h0040); wr(16'd3, 16'h0F0F); model[3] = 16'h0F0F;
        wr(16'd0, 16'h00C0);
        wr(16'd3, 16'h00A0);
        rd(16'd5, v); chk("R7 verify captured addr", v, 16'h0F0F);
        rd(16'd9, v); chk("R7 mode persists", v, 16'h0F0F);
        wr(16'd0, 16'h0000);
        rd(16'd5, v); chk("R7 left on command", v, 16'hFFFF);

        // R9: erase stop timer
        wr(16'd0, 16'h0020); wr(16'd0, 16'h0020);
        for (int i = 0; i < (1 << AW); i++) model[i] = 16'hFFFF;
        repeat (ELIM + 5) @(negedge clk);
        chk("R9 erase timed out", {15'h0, busy}, 16'h0);
        wr(16'd0, 16'h0000);

        // R4/R5 random program and readback
        for (int i = 0; i < 40; i++) begin
            logic [15:0] a, d, b;
            a = 16'($urandom % (1 << AW));
            d = 16'($urandom);
            if (d == 16'h00FF) d = 16'h0000;
            b = 16'($urandom % (1 << AW));
            wr(16'd0, 16'h0040);
            wr(a, d); model[a[AW-1:0]] = exp_prog(model[a[AW-1:0]], d);
            wr(16'd0, 16'h00C0);
            rd(16'($urandom % (1 << AW)), v); chk("R5 random verify", v, model[a[AW-1:0]]);
            wr(16'd0, 16'h0000);
            rd(b, v); chk("R4 random read", v, model[b[AW-1:0]]);
        end

        finish_run();
    end
endmodule